// File: doc/BRIEF.md
# Interrupt Priority and Software Request Unit

This unit holds the processor's current interrupt priority level and the set of pending software interrupt requests. Each cycle it looks at the hardware request lines, the halt request and the pending software levels. It compares them with the current level and decides whether an interrupt is taken. When one is taken, it gives the dispatch vector offset and the priority level the processor moves to. It writes that new level into its own priority register on the next clock edge.

Software sets the priority level with a direct write. It posts a software request by writing a 4-bit level number, and that write marks the level pending. Four bus request lines sit at levels 0x14 to 0x17. Taking any of them always moves the processor to level 0x17, because the bus cannot tell the levels apart. A rising halt request is nonmaskable and moves the processor to level 0x1F. Saving the program counter and status word, switching stacks and running the firmware halt handler are done elsewhere.

Top module: `ipr_intr_unit`

## Requirements
- R1: While reset is low, the current level reads 0x1F, the pending summary reads 0 and take is low.
- R2: A request write with level n in 1..15 sets bit n of the 16-bit pending summary from the next edge. A write with level 0 changes nothing. Bit 0 of the summary always reads 0.
- R3: A priority write loads the 5-bit value into the current level from the next edge, unless an interrupt is taken in the same cycle.
- R4: A maskable source is eligible only when its level is strictly greater than the current level. Take is a combinational result of the current state and the inputs in the same cycle.
- R5: When a software level is taken, it is the highest-numbered pending level above the current level. The vector offset is 0x80 + 4·n and the new level is n.
- R6: Bus line i (bit i of `hw_req`) has level 0x14+i. When any eligible line is taken, the new level is 0x17 and the vector offset is `bus_vec` + 0x200.
- R7: When a bus line and a software level are both eligible, the bus line is taken.
- R8: A rising edge of `halt_req` is taken whatever the current level, and it beats every other source. Its new level is 0x1F and its vector offset is 0. A held-high halt request is taken only once.
- R9: On the edge after take, the current level equals the new level that was presented. This takes precedence over a priority write in the same cycle.
- R10: Taking software level n clears pending bit n. A request write for the same level in the same cycle leaves the bit set.
- R11: While take is low, the vector offset and new level outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lvl_wr | input | 1 | Priority level write strobe |
| lvl_wdata | input | 5 | Priority level write value |
| sreq_wr | input | 1 | Software request write strobe |
| sreq_wdata | input | 4 | Software request level |
| hw_req | input | 4 | Bus request lines, bit i at level 0x14+i |
| bus_vec | input | 9 | Vector supplied by the requesting bus device |
| halt_req | input | 1 | Nonmaskable halt request |
| take | output | 1 | An interrupt is taken this cycle |
| vec_off | output | 10 | Dispatch vector offset |
| new_ipl | output | 5 | Priority level to adopt |
| cur_ipl | output | 5 | Current priority level |
| soft_pend | output | 16 | Pending software request summary |

## Verification
Take, vector offset and new level are combinational. They are due in the same cycle as the inputs that cause them, so the bench drives inputs just after a falling edge and compares these outputs a moment later, before the rising edge. The current level and the pending summary are registered. They change one edge after the write or the take, so the reference model applies its state update only after the comparison for the cycle is complete, and the next cycle's comparison sees the new values. The halt edge detector adds one cycle of memory, which the model keeps as the previous halt input.

// File: rtl/ipr_pkg.sv
// Shared definitions for the interrupt priority unit.
// Assumes: levels are 5-bit, software levels fit in 4 bits.
package ipr_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SOFT = 2'd1,
        SRC_BUS  = 2'd2,
        SRC_HALT = 2'd3
    } int_src_t;
endpackage

// File: rtl/ipr_soft_pend.sv
// Pending software request register with highest-eligible selection.
// Assumes: bit 0 never stores a request; a set and a clear of the same
// bit in one cycle leave it set.
module ipr_soft_pend #(
    parameter int PEND_W = 16,
    parameter int LVL_W  = 5,
    localparam int SEL_W = $clog2(PEND_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [SEL_W-1:0]  set_lvl,
    input  logic              clr_en,
    input  logic [SEL_W-1:0]  clr_lvl,
    input  logic [LVL_W-1:0]  thresh,
    output logic [PEND_W-1:0] pend,
    output logic              hit,
    output logic [SEL_W-1:0]  hit_lvl
);
    assign pend[0] = 1'b0;

    genvar k;
    generate
        for (k = 1; k < PEND_W; k++) begin : g_bit
            // Holds one pending level; set beats clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pend[k] <= 1'b0;
                else if (set_en && (set_lvl == SEL_W'(k)))
                    pend[k] <= 1'b1;
                else if (clr_en && (clr_lvl == SEL_W'(k)))
                    pend[k] <= 1'b0;
            end
        end
    endgenerate

    // Picks the highest pending level above the threshold.
    always_comb begin
        hit     = 1'b0;
        hit_lvl = '0;
        for (int i = 1; i < PEND_W; i++) begin
            if (pend[i] && (LVL_W'(i) > thresh)) begin
                hit     = 1'b1;
                hit_lvl = SEL_W'(i);
            end
        end
    end
endmodule

// File: rtl/ipr_hw_sel.sv
// Eligibility of the bus request lines against the current level.
// Assumes: line i requests at level BASE_LVL + i.
module ipr_hw_sel #(
    parameter int LINES    = 4,
    parameter int LVL_W    = 5,
    parameter int BASE_LVL = 'h14
) (
    input  logic [LINES-1:0] lines,
    input  logic [LVL_W-1:0] thresh,
    output logic             hit
);
    logic [LINES-1:0] elig;

    genvar i;
    generate
        for (i = 0; i < LINES; i++) begin : g_line
            assign elig[i] = lines[i] && (LVL_W'(BASE_LVL + i) > thresh);
        end
    endgenerate

    // Any eligible line is enough: the adopted level is fixed.
    always_comb hit = |elig;
endmodule

// File: rtl/ipr_arb.sv
// Final choice among halt, bus and software sources; forms outputs.
// Assumes: inputs already filtered for eligibility.
module ipr_arb
    import ipr_pkg::*;
#(
    parameter int LVL_W       = 5,
    parameter int SEL_W       = 4,
    parameter int BUSVEC_W    = 9,
    parameter int VEC_W       = 10,
    parameter int BUS_LVL     = 'h17,
    parameter int HALT_LVL    = 'h1F,
    parameter int SW_VEC_BASE = 'h80,
    parameter int HW_VEC_BASE = 'h200
) (
    input  logic                halt_hit,
    input  logic                bus_hit,
    input  logic                sw_hit,
    input  logic [SEL_W-1:0]    sw_lvl,
    input  logic [BUSVEC_W-1:0] bus_vec,
    output logic                take,
    output logic                sw_take,
    output logic [VEC_W-1:0]    vec_off,
    output logic [LVL_W-1:0]    new_ipl
);
    int_src_t src;

    // Fixed priority: halt, then bus, then software.
    always_comb begin
        if (halt_hit)     src = SRC_HALT;
        else if (bus_hit) src = SRC_BUS;
        else if (sw_hit)  src = SRC_SOFT;
        else              src = SRC_NONE;
    end

    // Builds vector offset and new level for the chosen source.
    always_comb begin
        take    = (src != SRC_NONE);
        sw_take = (src == SRC_SOFT);
        vec_off = '0;
        new_ipl = '0;
        case (src)
            SRC_HALT: new_ipl = LVL_W'(HALT_LVL);
            SRC_BUS: begin
                new_ipl = LVL_W'(BUS_LVL);
                vec_off = VEC_W'(HW_VEC_BASE) + VEC_W'(bus_vec);
            end
            SRC_SOFT: begin
                new_ipl = LVL_W'(sw_lvl);
                vec_off = VEC_W'(SW_VEC_BASE) + (VEC_W'(sw_lvl) << 2);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ipr_intr_unit.sv
// Top: current priority level, halt edge detect, and the three sources.
// Assumes: software adopts take in the same cycle; level reset is 0x1F.
module ipr_intr_unit #(
    parameter int LVL_W       = 5,
    parameter int PEND_W      = 16,
    parameter int HW_LINES    = 4,
    parameter int HW_BASE     = 'h14,
    parameter int BUS_LVL     = 'h17,
    parameter int HALT_LVL    = 'h1F,
    parameter int BUSVEC_W    = 9,
    parameter int VEC_W       = 10,
    parameter int SW_VEC_BASE = 'h80,
    parameter int HW_VEC_BASE = 'h200,
    localparam int SEL_W      = $clog2(PEND_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lvl_wr,
    input  logic [LVL_W-1:0]    lvl_wdata,
    input  logic                sreq_wr,
    input  logic [SEL_W-1:0]    sreq_wdata,
    input  logic [HW_LINES-1:0] hw_req,
    input  logic [BUSVEC_W-1:0] bus_vec,
    input  logic                halt_req,
    output logic                take,
    output logic [VEC_W-1:0]    vec_off,
    output logic [LVL_W-1:0]    new_ipl,
    output logic [LVL_W-1:0]    cur_ipl,
    output logic [PEND_W-1:0]   soft_pend
);
    logic             halt_prev;
    logic             halt_hit;
    logic             bus_hit;
    logic             sw_hit;
    logic [SEL_W-1:0] sw_lvl;
    logic             sw_take;

    // Remembers last halt input for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) halt_prev <= 1'b0;
        else        halt_prev <= halt_req;
    end

    assign halt_hit = halt_req && !halt_prev;

    // Current level: a take wins over a direct write.
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_ipl <= LVL_W'(HALT_LVL);
        else if (take)   cur_ipl <= new_ipl;
        else if (lvl_wr) cur_ipl <= lvl_wdata;
    end

    ipr_soft_pend #(
        .PEND_W (PEND_W),
        .LVL_W  (LVL_W)
    ) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (sreq_wr && (sreq_wdata != '0)),
        .set_lvl (sreq_wdata),
        .clr_en  (sw_take),
        .clr_lvl (sw_lvl),
        .thresh  (cur_ipl),
        .pend    (soft_pend),
        .hit     (sw_hit),
        .hit_lvl (sw_lvl)
    );

    ipr_hw_sel #(
        .LINES    (HW_LINES),
        .LVL_W    (LVL_W),
        .BASE_LVL (HW_BASE)
    ) u_hw (
        .lines  (hw_req),
        .thresh (cur_ipl),
        .hit    (bus_hit)
    );

    ipr_arb #(
        .LVL_W       (LVL_W),
        .SEL_W       (SEL_W),
        .BUSVEC_W    (BUSVEC_W),
        .VEC_W       (VEC_W),
        .BUS_LVL     (BUS_LVL),
        .HALT_LVL    (HALT_LVL),
        .SW_VEC_BASE (SW_VEC_BASE),
        .HW_VEC_BASE (HW_VEC_BASE)
    ) u_arb (
        .halt_hit (halt_hit),
        .bus_hit  (bus_hit),
        .sw_hit   (sw_hit),
        .sw_lvl   (sw_lvl),
        .bus_vec  (bus_vec),
        .take     (take),
        .sw_take  (sw_take),
        .vec_off  (vec_off),
        .new_ipl  (new_ipl)
    );
endmodule

// File: rtl/ipr_intr_chk.sv
// Protocol checks on the priority unit's ports, bound to the top.
// Assumes: default parameter set of the top module.
module ipr_intr_chk #(
    parameter int LVL_W    = 5,
    parameter int PEND_W   = 16,
    parameter int HW_LINES = 4,
    parameter int VEC_W    = 10,
    parameter int BUS_LVL  = 'h17,
    parameter int HALT_LVL = 'h1F,
    localparam int SEL_W   = $clog2(PEND_W)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sreq_wr,
    input logic [SEL_W-1:0]    sreq_wdata,
    input logic [HW_LINES-1:0] hw_req,
    input logic                halt_req,
    input logic                take,
    input logic [VEC_W-1:0]    vec_off,
    input logic [LVL_W-1:0]    new_ipl,
    input logic [LVL_W-1:0]    cur_ipl,
    input logic [PEND_W-1:0]   soft_pend
);
    p_pend_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sreq_wr && sreq_wdata != '0) |=> soft_pend[$past(sreq_wdata)]);

    p_bit0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_pend[0]);

    p_above_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (new_ipl > cur_ipl) || halt_req);

    p_bus_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && hw_req != '0 && !halt_req) |-> new_ipl == LVL_W'(BUS_LVL));

    p_halt_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req) |-> take && new_ipl == LVL_W'(HALT_LVL) && vec_off == '0);

    p_level_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> cur_ipl == $past(new_ipl));

    p_sw_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && new_ipl != '0 && new_ipl < LVL_W'(PEND_W)
         && !(sreq_wr && LVL_W'(sreq_wdata) == new_ipl))
        |=> !soft_pend[$past(new_ipl[SEL_W-1:0])]);

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> vec_off == '0 && new_ipl == '0);
endmodule

bind ipr_intr_unit ipr_intr_chk #(
    .LVL_W    (LVL_W),
    .PEND_W   (PEND_W),
    .HW_LINES (HW_LINES),
    .VEC_W    (VEC_W),
    .BUS_LVL  (BUS_LVL),
    .HALT_LVL (HALT_LVL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sreq_wr    (sreq_wr),
    .sreq_wdata (sreq_wdata),
    .hw_req     (hw_req),
    .halt_req   (halt_req),
    .take       (take),
    .vec_off    (vec_off),
    .new_ipl    (new_ipl),
    .cur_ipl    (cur_ipl),
    .soft_pend  (soft_pend)
);

// File: tb/tb_ipr_intr_unit.sv
// Random-stimulus bench with a behavioural reference model checked each cycle.
module tb_ipr_intr_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N_CYCLES   = 6000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lvl_wr;
    logic [4:0]  lvl_wdata;
    logic        sreq_wr;
    logic [3:0]  sreq_wdata;
    logic [3:0]  hw_req;
    logic [8:0]  bus_vec;
    logic        halt_req;
    logic        take;
    logic [9:0]  vec_off;
    logic [4:0]  new_ipl;
    logic [4:0]  cur_ipl;
    logic [15:0] soft_pend;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state.
    int m_ipl;
    int m_pend;
    int m_hprev;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipr_intr_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_wr     (lvl_wr),
        .lvl_wdata  (lvl_wdata),
        .sreq_wr    (sreq_wr),
        .sreq_wdata (sreq_wdata),
        .hw_req     (hw_req),
        .bus_vec    (bus_vec),
        .halt_req   (halt_req),
        .take       (take),
        .vec_off    (vec_off),
        .new_ipl    (new_ipl),
        .cur_ipl    (cur_ipl),
        .soft_pend  (soft_pend)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compares the outputs of the current cycle, then advances the model.
    task automatic step_check();
        int hw_best, sw_best, e_take, e_vec, e_new;
        bit halt_t;
        string tag;
        halt_t  = halt_req && (m_hprev == 0);
        hw_best = -1;
        for (int i = 0; i < 4; i++)
            if (hw_req[i] && (8'h14 + i) > m_ipl) hw_best = i;
        sw_best = -1;
        for (int n = 1; n < 16; n++)
            if (m_pend[n] && n > m_ipl) sw_best = n;
        if (halt_t) begin
            e_take = 1; e_vec = 0; e_new = 'h1F; tag = "R8";
        end else if (hw_best >= 0) begin
            e_take = 1; e_vec = 'h200 + bus_vec; e_new = 'h17;
            tag = (sw_best >= 0) ? "R7" : "R6";
        end else if (sw_best >= 0) begin
            e_take = 1; e_vec = 'h80 + 4 * sw_best; e_new = sw_best; tag = "R5";
        end else begin
            e_take = 0; e_vec = 0; e_new = 0; tag = "R11";
        end
        chk({"R4/", tag}, "take", take, e_take);
        chk(tag, "vec_off", vec_off, e_vec);
        chk(tag, "new_ipl", new_ipl, e_new);
        chk("R3/R9", "cur_ipl", cur_ipl, m_ipl);
        chk("R2/R10", "soft_pend", soft_pend, m_pend);
        // Next state, as the registers will hold it after the edge.
        if (e_take && !halt_t && hw_best < 0) m_pend = m_pend & ~(1 << sw_best);
        if (sreq_wr && sreq_wdata != 0) m_pend = m_pend | (1 << sreq_wdata);
        if (e_take)      m_ipl = e_new;
        else if (lvl_wr) m_ipl = lvl_wdata;
        m_hprev = halt_req;
    endtask

    initial begin
        rst_n = 1'b0; lvl_wr = 0; lvl_wdata = 0; sreq_wr = 0; sreq_wdata = 0;
        hw_req = 0; bus_vec = 0; halt_req = 0;
        m_ipl = 'h1F; m_pend = 0; m_hprev = 0;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk("R1", "cur_ipl", cur_ipl, 'h1F);
        chk("R1", "soft_pend", soft_pend, 0);
        chk("R1", "take", take, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // Directed: level-0 request write is ignored (R2), then drop level.
        sreq_wr = 1; sreq_wdata = 0;
        #1 step_check();
        @(negedge clk);
        sreq_wr = 0; lvl_wr = 1; lvl_wdata = 0;
        #1 step_check();
        @(negedge clk);
        lvl_wr = 0;
        #1 step_check();
        chk("R2", "soft_pend after level 0 write", soft_pend, 0);
        for (int c = 0; c < N_CYCLES; c++) begin
            @(negedge clk);
            lvl_wr     = ($urandom_range(0, 19) == 0);
            lvl_wdata  = ($urandom_range(0, 1) == 0) ? 5'($urandom_range(0, 15))
                                                     : 5'($urandom_range(0, 31));
            sreq_wr    = ($urandom_range(0, 2) == 0);
            sreq_wdata = 4'($urandom_range(0, 15));
            hw_req     = 4'(($urandom_range(0, 7) == 0) ? $urandom_range(1, 15) : 0);
            bus_vec    = 9'($urandom_range(0, 511));
            if ($urandom_range(0, 29) == 0) halt_req = ~halt_req;
            #1 step_check();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * (N_CYCLES + 1000));
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule